// File: doc/BRIEF.md
# Serial-In Latched Open-Drain Output Driver

This block takes a serial bit stream and a shift clock, collects the bits in a chain of register stages, and hands a snapshot of the chain to a storage latch that controls a bank of pull-down outputs. Each output pin is modelled as a pull-down enable together with the level the pin settles to against an external pull-up. An active-low output enable can release every pull-down at once. A cascade output repeats the last chain stage on the falling shift-clock edge, so that several blocks can be chained.

All activity runs on one system clock. The shift clock, the latch control and the serial data are sampled through a configurable synchronizer, and the block reacts to the detected edges and levels. The intended sequence is to shift in a full word of bits and then pulse the latch control, which updates every output at the same moment. A latch pulse given earlier copies whatever partial pattern the chain holds at that time.

Top module: `serial_latch_driver`

## Requirements
- R1: A synchronous active-low reset clears the chain, the storage latch and the cascade flop to 0. With output enable low, every pull-down is then on and every pin reads 0.
- R2: On each rising shift-clock edge, stage 0 takes the serial input and stage i takes the old value of stage i-1. After STAGES shifts, stage 0 holds the last bit shifted in and stage STAGES-1 holds the first.
- R3: While the latch control is low, shifting leaves the storage latch, the pull-down enables and the pin levels unchanged.
- R4: While the latch control is high, the storage latch follows the chain, including bits shifted while it stays high. When the latch control falls, the latch keeps its last value.
- R5: With output enable low, the pull-down enable of bit i is 1 exactly when stored bit i is 0.
- R6: With output enable high, all pull-down enables are 0 and all pin levels are 1, whatever the latch holds.
- R7: The cascade output takes the value of stage STAGES-1 on the falling shift-clock edge and holds it otherwise. It does not depend on output enable.
- R8: An undriven (high-impedance) output enable acts as low, so the outputs are enabled.
- R9: A latch pulse after fewer than STAGES shifts transfers the partly shifted chain: the newly shifted bits sit in the low stages and the older contents sit above them.
- R10: Pin level i is 0 exactly when pull-down enable i is 1, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_in | input | 1 | Serial data input |
| shift_clk | input | 1 | Shift clock; the chain shifts on its rising edge |
| latch_ctl | input | 1 | Storage latch is transparent while high |
| oe_n | input | 1 | Active-low output enable; undriven counts as enabled |
| pd_en | output | STAGES | Pull-down enable per output pin |
| pin_level | output | STAGES | Resolved pin level with external pull-up |
| casc_out | output | 1 | Cascade output, last stage, updated on falling shift clock |

## Verification
A shift and an open latch can fall in the same cycle. In that case the latch first copies the chain as it was before the shift, then the shifted value on the next cycle. The bench provokes this by raising the latch control and the shift clock together, then closing the latch after the shift. It judges the result by checking that the pins show the chain after the shift. The cascade update and a change of output enable can also coincide; the bench toggles the enable during shifts and expects the cascade value to be unaffected.

// File: rtl/sld_pkg.sv
package sld_pkg;
   localparam int unsigned DEF_STAGES = 12;
   localparam int unsigned DEF_SYNC   = 2;

   // index of each sampled control in the synchronizer vector
   localparam int unsigned IDX_SCLK  = 0;
   localparam int unsigned IDX_LATCH = 1;
   localparam int unsigned IDX_DATA  = 2;
   localparam int unsigned CTRL_W    = 3;

   typedef struct packed {
      logic rise;
      logic fall;
      logic level;
   } edge_info_t;

   function automatic logic resolve_pin(input logic pull_down);
      return pull_down ? 1'b0 : 1'b1;
   endfunction
endpackage

// File: rtl/sld_edge_sync.sv
module sld_edge_sync #(
   parameter int unsigned W           = 3,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] raw,
   output logic [W-1:0] level,
   output logic [W-1:0] rise,
   output logic [W-1:0] fall
);
   logic [W-1:0] prev_q;

   generate
      if (SYNC_STAGES == 0) begin : g_bypass
         assign level = raw;
      end else begin : g_chain
         logic [W-1:0] sync_q [SYNC_STAGES];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int k = 0; k < SYNC_STAGES; k++) sync_q[k] <= '0;
            end else begin
               sync_q[0] <= raw;
               for (int k = 1; k < SYNC_STAGES; k++) sync_q[k] <= sync_q[k-1];
            end
         end
         assign level = sync_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= level;
   end

   assign rise = level & ~prev_q;
   assign fall = ~level & prev_q;
endmodule

// File: rtl/sld_shift_chain.sv
module sld_shift_chain #(
   parameter int unsigned STAGES = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic              bit_in,
   output logic [STAGES-1:0] q
);
   genvar g;
   generate
      for (g = 0; g < STAGES; g++) begin : g_stage
         logic src;
         if (g == 0) begin : g_head
            assign src = bit_in;
         end else begin : g_body
            assign src = q[g-1];
         end
         always_ff @(posedge clk) begin
            if (!rst_n)    q[g] <= 1'b0;
            else if (step) q[g] <= src;
         end
      end
   endgenerate
endmodule

// File: rtl/sld_store_latch.sv
module sld_store_latch #(
   parameter int unsigned STAGES = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              open_i,
   input  logic [STAGES-1:0] d,
   output logic [STAGES-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)      q <= '0;
      else if (open_i) q <= d;
   end
endmodule

// File: rtl/sld_pin_drive.sv
module sld_pin_drive
   import sld_pkg::*;
#(
   parameter int unsigned STAGES = 12
) (
   input  logic              enable,
   input  logic [STAGES-1:0] stored,
   output logic [STAGES-1:0] pd_en,
   output logic [STAGES-1:0] pin_level
);
   genvar g;
   generate
      for (g = 0; g < STAGES; g++) begin : g_pin
         assign pd_en[g]     = enable & ~stored[g];
         assign pin_level[g] = resolve_pin(pd_en[g]);
      end
   endgenerate
endmodule

// File: rtl/serial_latch_driver.sv
module serial_latch_driver
   import sld_pkg::*;
#(
   parameter int unsigned STAGES      = DEF_STAGES,
   parameter int unsigned SYNC_STAGES = DEF_SYNC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_in,
   input  logic              shift_clk,
   input  logic              latch_ctl,
   input  logic              oe_n,
   output logic [STAGES-1:0] pd_en,
   output logic [STAGES-1:0] pin_level,
   output logic              casc_out
);
   localparam int unsigned LAST = STAGES - 1;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("serial_latch_driver: STAGES must be at least 2");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("serial_latch_driver: SYNC_STAGES must be 0 to 4");
      end
   endgenerate

   logic [CTRL_W-1:0] raw_v, lvl_v, rise_v, fall_v;
   edge_info_t        sclk_i;
   logic              latch_open;
   logic              data_s;
   logic              oe_on;
   logic [STAGES-1:0] chain_q;
   logic [STAGES-1:0] store_q;
   logic              casc_q;

   // an undriven enable resolves as low (internal pull-down)
   assign oe_on = (oe_n !== 1'b1);

   always_comb begin
      raw_v            = '0;
      raw_v[IDX_SCLK]  = shift_clk;
      raw_v[IDX_LATCH] = latch_ctl;
      raw_v[IDX_DATA]  = ser_in;
   end

   sld_edge_sync #(.W(CTRL_W), .SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .raw(raw_v),
      .level(lvl_v), .rise(rise_v), .fall(fall_v)
   );

   assign sclk_i.rise  = rise_v[IDX_SCLK];
   assign sclk_i.fall  = fall_v[IDX_SCLK];
   assign sclk_i.level = lvl_v[IDX_SCLK];
   assign latch_open   = lvl_v[IDX_LATCH];
   assign data_s       = lvl_v[IDX_DATA];

   sld_shift_chain #(.STAGES(STAGES)) u_chain (
      .clk(clk), .rst_n(rst_n), .step(sclk_i.rise), .bit_in(data_s), .q(chain_q)
   );

   sld_store_latch #(.STAGES(STAGES)) u_store (
      .clk(clk), .rst_n(rst_n), .open_i(latch_open), .d(chain_q), .q(store_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)           casc_q <= 1'b0;
      else if (sclk_i.fall) casc_q <= chain_q[LAST];
   end
   assign casc_out = casc_q;

   sld_pin_drive #(.STAGES(STAGES)) u_pins (
      .enable(oe_on), .stored(store_q), .pd_en(pd_en), .pin_level(pin_level)
   );
endmodule

module sld_checker #(
   parameter int unsigned STAGES = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              step,
   input logic              fall_step,
   input logic              bit_in,
   input logic              latch_open,
   input logic              oe_on,
   input logic [STAGES-1:0] chain_q,
   input logic [STAGES-1:0] store_q,
   input logic [STAGES-1:0] pd_en,
   input logic [STAGES-1:0] pin_level,
   input logic              casc_out
);
   // R2
   shift_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> chain_q == {$past(chain_q[STAGES-2:0]), $past(bit_in)});
   // R3
   latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !latch_open |=> $stable(store_q));
   // R4
   latch_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      latch_open |=> store_q == $past(chain_q));
   // R5
   pd_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
      oe_on |-> pd_en == ~store_q);
   // R6
   released_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_on |-> (pd_en == '0 && pin_level == '1));
   // R7
   casc_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fall_step |=> casc_out == $past(chain_q[STAGES-1]));
   // R7
   casc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fall_step |=> $stable(casc_out));
endmodule

bind serial_latch_driver sld_checker #(.STAGES(STAGES)) u_chk (
   .clk(clk), .rst_n(rst_n), .step(sclk_i.rise), .fall_step(sclk_i.fall),
   .bit_in(data_s), .latch_open(latch_open), .oe_on(oe_on),
   .chain_q(chain_q), .store_q(store_q), .pd_en(pd_en),
   .pin_level(pin_level), .casc_out(casc_out)
);

// File: tb/serial_latch_driver_test.sv
module serial_latch_driver_test;
   localparam int CLK_PERIOD = 10;
   localparam int N = 12;
   localparam int HOLD = 5;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         ser_in, shift_clk, latch_ctl, oe_n;
   logic [N-1:0] pd_en, pin_level;
   logic         casc_out;

   int checks = 0;
   int errors = 0;

   logic [N-1:0] model_chain;
   logic [N-1:0] model_store;
   logic         model_casc;

   always #(CLK_PERIOD/2) clk = ~clk;

   serial_latch_driver #(.STAGES(N), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .shift_clk(shift_clk),
      .latch_ctl(latch_ctl), .oe_n(oe_n), .pd_en(pd_en),
      .pin_level(pin_level), .casc_out(casc_out)
   );

   task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wait_cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // pins with output enabled follow the modelled store
   task automatic check_pins(input string req);
      check({req, " pd_en"}, pd_en, ~model_store);
      check({req, " pin_level (R10)"}, pin_level, model_store);
   endtask

   task automatic shift_bit(input logic b);
      @(negedge clk);
      ser_in    = b;
      shift_clk = 1'b1;
      wait_cycles(HOLD);
      model_chain = {model_chain[N-2:0], b};
      // R7: cascade still shows the old last stage before the falling edge
      check("R7 cascade lag", {{(N-1){1'b0}}, casc_out}, {{(N-1){1'b0}}, model_casc});
      shift_clk = 1'b0;
      wait_cycles(HOLD);
      model_casc = model_chain[N-1];
      check("R7 cascade update", {{(N-1){1'b0}}, casc_out}, {{(N-1){1'b0}}, model_casc});
   endtask

   task automatic shift_word(input logic [N-1:0] w, input int count);
      for (int i = count - 1; i >= 0; i--) shift_bit(w[i]);
   endtask

   task automatic pulse_latch();
      @(negedge clk);
      latch_ctl = 1'b1;
      wait_cycles(HOLD);
      latch_ctl = 1'b0;
      model_store = model_chain;
      wait_cycles(HOLD);
   endtask

   task automatic t_reset();
      rst_n = 1'b0; ser_in = 1'b0; shift_clk = 1'b0; latch_ctl = 1'b0; oe_n = 1'b0;
      wait_cycles(4);
      rst_n = 1'b1;
      wait_cycles(2);
      model_chain = '0; model_store = '0; model_casc = 1'b0;
      check("R1 pd_en after reset", pd_en, '1);
      check("R1 pin_level after reset", pin_level, '0);
      check("R1 cascade after reset", {{(N-1){1'b0}}, casc_out}, '0);
   endtask

   task automatic t_full_load();
      shift_word(12'hA5C, N);
      // R3: outputs untouched by shifting while latch is closed
      check_pins("R3 hold during shift");
      pulse_latch();
      check_pins("R2 R4 R5 full word");
   endtask

   task automatic t_hold_then_reload();
      shift_word(12'h3F0, N);
      check_pins("R3 second word not yet latched");
      pulse_latch();
      check_pins("R4 second word latched");
   endtask

   task automatic t_partial();
      shift_word(12'h015, 5);
      pulse_latch();
      // R9: five new bits low, older bits moved up
      check("R9 partial pattern", pin_level, 12'h015 | (12'h3F0 << 5));
      check_pins("R9 partial pins");
   endtask

   task automatic t_oe();
      @(negedge clk);
      oe_n = 1'b1;
      @(negedge clk);
      check("R6 released pd_en", pd_en, '0);
      check("R6 released pins", pin_level, '1);
      // R7: cascade keeps working with outputs released
      shift_bit(1'b1);
      shift_bit(1'b0);
      check("R6 still released", pin_level, '1);
      oe_n = 1'bz;
      @(negedge clk);
      check_pins("R8 undriven enable");
      oe_n = 1'b0;
      @(negedge clk);
      check_pins("R5 re-enabled");
   endtask

   task automatic t_concurrent();
      @(negedge clk);
      latch_ctl = 1'b1;
      ser_in    = 1'b1;
      shift_clk = 1'b1;
      wait_cycles(HOLD);
      model_chain = {model_chain[N-2:0], 1'b1};
      shift_clk = 1'b0;
      wait_cycles(HOLD);
      model_casc = model_chain[N-1];
      latch_ctl = 1'b0;
      model_store = model_chain;
      wait_cycles(HOLD);
      check_pins("R4 shift while latch open");
      check("R7 concurrent cascade", {{(N-1){1'b0}}, casc_out}, {{(N-1){1'b0}}, model_casc});
   endtask

   initial begin
      fork
         begin
            t_reset();
            t_full_load();
            t_hold_then_reload();
            t_partial();
            t_oe();
            t_concurrent();
         end
         begin
            repeat (100000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule